// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This block orders the enables of six supply rails for a display power unit. When the chip enable is high and both the input-supply monitor and the thermal monitor report healthy conditions, the rails turn on one at a time. Each rail has its own turn-on time, counted in timebase ticks from the moment the sequence starts. A power-good flag follows the last rail by one tick.

When the enable is released, the rails go off in a different order: the positive rails first, then the negative ones, with the reference last. Each turn-off waits a parameterized number of ticks after the previous one, and these waits are much longer than the turn-on spacing. An input-undervoltage or over-temperature indication skips the timed order and drops every rail at once. After such a fault, the enable must be seen low while the fault is clear before the block can start again.

All times are counted in ticks of an external timebase pulse. The default values assume a 0.5 ms tick.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is asserted, and after reset with the enable low, every rail enable and the power-good flag are 0.
- R2: Rail enable bits map as bit0 reference, bit1 gate-low pump, bit2 negative source, bit3 common-electrode buffer, bit4 gate-high pump, bit5 positive source. The sequence starts when the block is idle and samples the enable high with both monitors healthy. Rail i turns on at the clock edge of the UP_TICKS[i]-th tick after that start edge. Rails turn on strictly in bit order, one per tick.
- R3: Power-good rises on tick UP_TICKS[5]+1 of the power-up. It falls on the same edge as the first rail that turns off. It is never high unless all six rails are on.
- R4: After the enable is sampled low with all rails on, bit5 turns off at the next edge. Rail j (j = 4 down to 0) then turns off on the DOWN_GAP_TICKS[j]-th tick after the previous rail turned off. At most one rail changes per edge while no fault is present.
- R5: If the enable is sampled low during power-up, the highest rail already on turns off at the next edge, and the remaining rails follow the R4 order and gaps. If no rail is on yet, nothing turns on and the block returns to idle. No rail turns on while the enable is low.
- R6: When the undervoltage monitor reports low input (uvlo_ok = 0), all rail enables and power-good are 0 after the next edge, in any state, and no rail turns on while it stays low.
- R7: When the thermal monitor reports over-temperature (thermal_ok = 0), all rail enables and power-good are 0 after the next edge, in any state.
- R8: After a fault, no rail turns on until the enable has been sampled low with both monitors healthy. A later rising enable then starts a normal power-up.
- R9: Once a power-down has started, it runs to completion even if the enable returns high. A new power-up begins only after the last rail has turned off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse |
| en | input | 1 | Chip enable |
| uvlo_ok | input | 1 | High when the input supply is above its undervoltage limit |
| thermal_ok | input | 1 | High when the die temperature is below its shutdown limit |
| rail_en | output | 6 | Per-rail enables (bit mapping in R2) |
| pwr_good | output | 1 | All rails up and settled for one tick |

## Verification
Timed results land on the clock edge where the deciding tick pulse is sampled. Responses to the enable falling or to a fault land on the first edge after the input is sampled. The bench drives every input on the falling clock edge. It counts tick pulses at rising edges to reach the edge a result is due on, and checks the outputs one nanosecond after that edge. The bench also checks the output one tick before each milestone to pin the exact tick count. The power-up and power-down timing is walked from a step table. Aborts, faults and restarts are directed tests.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
   localparam int unsigned RAIL_COUNT = 6;
   localparam int unsigned GAP_COUNT  = RAIL_COUNT - 1;
   localparam int unsigned IDX_W      = $clog2(RAIL_COUNT);

   typedef enum logic [2:0] {
      SEQ_IDLE  = 3'd0,
      SEQ_RISE  = 3'd1,
      SEQ_HOLD  = 3'd2,
      SEQ_FALL  = 3'd3,
      SEQ_TRIP  = 3'd4
   } seq_state_t;
endpackage

// File: rtl/rseq_tick_counter.sv
module rseq_tick_counter #(
   parameter int unsigned CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [CNT_W-1:0] count_inc
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 2) begin : g_bad_width
      $error("rseq_tick_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] count_q;

   assign count_inc = (count_q == CNT_MAX) ? CNT_MAX : count_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count_q <= '0;
      else if (clear)  count_q <= '0;
      else if (step)   count_q <= count_inc;
   end

   AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count_inc == CNT_W'(1))); // R4
endmodule

// File: rtl/rseq_milestone_cmp.sv
module rseq_milestone_cmp #(
   parameter int unsigned N     = 6,
   parameter int unsigned CNT_W = 13,
   parameter int unsigned AT [N] = '{default: 1}
) (
   input  logic [CNT_W-1:0] count_inc,
   output logic [N-1:0]     reached,
   output logic             settled
);
   for (genvar g = 0; g < N; g++) begin : g_rail
      if (AT[g] < 1) begin : g_zero
         $error("rseq_milestone_cmp: milestone must be at least one tick");
      end
      if (64'(AT[g]) + 64'd1 >= (64'd1 << CNT_W)) begin : g_range
         $error("rseq_milestone_cmp: milestone does not fit the counter");
      end
      if (g > 0) begin : g_order
         if (AT[g] <= AT[g-1]) begin : g_bad
            $error("rseq_milestone_cmp: milestones must rise strictly");
         end
      end
      assign reached[g] = (count_inc >= CNT_W'(AT[g]));
   end

   assign settled = (count_inc > CNT_W'(AT[N-1]));
endmodule

// File: rtl/rseq_gap_select.sv
module rseq_gap_select #(
   parameter int unsigned N_GAPS = 5,
   parameter int unsigned CNT_W  = 13,
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned GAP [N_GAPS] = '{default: 1}
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [CNT_W-1:0] count_inc,
   output logic             gap_done
);
   logic [N_GAPS-1:0] done_vec;

   for (genvar g = 0; g < N_GAPS; g++) begin : g_gap
      if (GAP[g] < 1) begin : g_zero
         $error("rseq_gap_select: gap must be at least one tick");
      end
      if (64'(GAP[g]) >= (64'd1 << CNT_W)) begin : g_range
         $error("rseq_gap_select: gap does not fit the counter");
      end
      assign done_vec[g] = (count_inc >= CNT_W'(GAP[g]));
   end

   assign gap_done = (idx < IDX_W'(N_GAPS)) ? done_vec[idx] : 1'b1;
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
   import rseq_pkg::*;
#(
   parameter int unsigned CNT_W = 13,
   parameter int unsigned UP_TICKS [RAIL_COUNT] = '{1, 10, 26, 32, 33, 38},
   parameter int unsigned DOWN_GAP_TICKS [GAP_COUNT] = '{4000, 20, 3000, 4000, 20}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  en,
   input  logic                  uvlo_ok,
   input  logic                  thermal_ok,
   output logic [RAIL_COUNT-1:0] rail_en,
   output logic                  pwr_good
);
   localparam logic [RAIL_COUNT-1:0] ALL_ON = '1;

   seq_state_t            state_q, state_d;
   logic [RAIL_COUNT-1:0] rails_q, rails_d;
   logic                  pg_q, pg_d;
   logic [IDX_W-1:0]      idx_q, idx_d;
   logic                  cnt_clear;
   logic [CNT_W-1:0]      count_inc;
   logic [RAIL_COUNT-1:0] reached;
   logic                  settled;
   logic                  gap_done;
   logic                  fault;
   logic [IDX_W-1:0]      top_on;

   function automatic logic [IDX_W-1:0] highest_on(input logic [RAIL_COUNT-1:0] r);
      logic [IDX_W-1:0] v;
      v = '0;
      for (int i = 0; i < int'(RAIL_COUNT); i++) begin
         if (r[i]) v = IDX_W'(i);
      end
      return v;
   endfunction

   rseq_tick_counter #(.CNT_W(CNT_W)) i_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (cnt_clear),
      .step      (tick),
      .count_inc (count_inc)
   );

   rseq_milestone_cmp #(.N(RAIL_COUNT), .CNT_W(CNT_W), .AT(UP_TICKS)) i_milestones (
      .count_inc (count_inc),
      .reached   (reached),
      .settled   (settled)
   );

   rseq_gap_select #(.N_GAPS(GAP_COUNT), .CNT_W(CNT_W), .IDX_W(IDX_W),
                     .GAP(DOWN_GAP_TICKS)) i_gaps (
      .idx       (idx_q),
      .count_inc (count_inc),
      .gap_done  (gap_done)
   );

   assign fault  = !uvlo_ok || !thermal_ok;
   assign top_on = highest_on(rails_q);

   always_comb begin
      state_d   = state_q;
      rails_d   = rails_q;
      pg_d      = pg_q;
      idx_d     = idx_q;
      cnt_clear = 1'b0;
      if (fault) begin
         state_d   = SEQ_TRIP;
         rails_d   = '0;
         pg_d      = 1'b0;
         cnt_clear = 1'b1;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               cnt_clear = 1'b1;
               if (en) state_d = SEQ_RISE;
            end
            SEQ_RISE, SEQ_HOLD: begin
               if (!en) begin
                  cnt_clear = 1'b1;
                  pg_d      = 1'b0;
                  if (rails_q == '0) begin
                     state_d = SEQ_IDLE;
                  end else begin
                     rails_d[top_on] = 1'b0;
                     if (top_on == '0) begin
                        state_d = SEQ_IDLE;
                     end else begin
                        idx_d   = top_on - IDX_W'(1);
                        state_d = SEQ_FALL;
                     end
                  end
               end else if (tick) begin
                  rails_d = rails_q | reached;
                  pg_d    = settled;
                  if (settled) state_d = SEQ_HOLD;
               end
            end
            SEQ_FALL: begin
               if (tick && gap_done) begin
                  rails_d[idx_q] = 1'b0;
                  cnt_clear      = 1'b1;
                  if (idx_q == '0) state_d = SEQ_IDLE;
                  else             idx_d   = idx_q - IDX_W'(1);
               end
            end
            SEQ_TRIP: begin
               cnt_clear = 1'b1;
               rails_d   = '0;
               pg_d      = 1'b0;
               if (!en) state_d = SEQ_IDLE;
            end
            default: begin
               state_d = SEQ_IDLE;
               rails_d = '0;
               pg_d    = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         rails_q <= '0;
         pg_q    <= 1'b0;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         rails_q <= rails_d;
         pg_q    <= pg_d;
         idx_q   <= idx_d;
      end
   end

   assign rail_en  = rails_q;
   assign pwr_good = pg_q;

   AST_TRIP_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (rail_en == '0 && !pwr_good)); // R6
   AST_PREFIX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ((rail_en & (rail_en + RAIL_COUNT'(1))) == '0)); // R2
   AST_GOOD_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_good |-> (rail_en == ALL_ON)); // R3
   AST_NO_RISE_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ((rail_en & ~$past(rail_en)) == '0)); // R5
   AST_ONE_RAIL_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |=> ($countones(rail_en ^ $past(rail_en)) <= 1)); // R4
endmodule

// File: tb/test_rail_sequencer.sv
`timescale 1ns/1ps
module test_rail_sequencer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       en = 1'b0;
   logic       uvlo_ok = 1'b1;
   logic       thermal_ok = 1'b1;
   logic [5:0] rail_en;
   logic       pwr_good;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   int tdiv = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rail_sequencer #(
      .CNT_W(8),
      .UP_TICKS('{2, 4, 9, 12, 13, 16}),
      .DOWN_GAP_TICKS('{6, 2, 5, 6, 2})
   ) i_rail_sequencer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en),
      .uvlo_ok(uvlo_ok), .thermal_ok(thermal_ok),
      .rail_en(rail_en), .pwr_good(pwr_good)
   );

   // timebase: one pulse every third cycle, changed on falling edges
   always @(negedge clk) begin
      tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
      tick <= (tdiv == 1);
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: run hung, cycles=%0d expected below 20000", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // {en, ticks to wait (0 = one edge), expected rails, expected power-good}
   localparam int NSTEP = 26;
   localparam logic [11:0] STEPS [NSTEP] = '{
      {1'b1, 4'd0, 6'b000000, 1'b0},
      {1'b1, 4'd1, 6'b000000, 1'b0},
      {1'b1, 4'd1, 6'b000001, 1'b0},
      {1'b1, 4'd1, 6'b000001, 1'b0},
      {1'b1, 4'd1, 6'b000011, 1'b0},
      {1'b1, 4'd4, 6'b000011, 1'b0},
      {1'b1, 4'd1, 6'b000111, 1'b0},
      {1'b1, 4'd2, 6'b000111, 1'b0},
      {1'b1, 4'd1, 6'b001111, 1'b0},
      {1'b1, 4'd1, 6'b011111, 1'b0},
      {1'b1, 4'd2, 6'b011111, 1'b0},
      {1'b1, 4'd1, 6'b111111, 1'b0},
      {1'b1, 4'd1, 6'b111111, 1'b1},
      {1'b1, 4'd3, 6'b111111, 1'b1},
      {1'b0, 4'd0, 6'b011111, 1'b0},
      {1'b0, 4'd1, 6'b011111, 1'b0},
      {1'b0, 4'd1, 6'b001111, 1'b0},
      {1'b0, 4'd5, 6'b001111, 1'b0},
      {1'b0, 4'd1, 6'b000111, 1'b0},
      {1'b0, 4'd4, 6'b000111, 1'b0},
      {1'b0, 4'd1, 6'b000011, 1'b0},
      {1'b0, 4'd1, 6'b000011, 1'b0},
      {1'b0, 4'd1, 6'b000001, 1'b0},
      {1'b0, 4'd5, 6'b000001, 1'b0},
      {1'b0, 4'd1, 6'b000000, 1'b0},
      {1'b0, 4'd2, 6'b000000, 1'b0}
   };

   task automatic check(input string req, input logic [5:0] exp_r, input logic exp_pg);
      checks++;
      if (rail_en !== exp_r || pwr_good !== exp_pg) begin
         fails++;
         $display("FAIL %s rail_en=%b expected %b, pwr_good=%b expected %b",
                  req, rail_en, exp_r, pwr_good, exp_pg);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         do @(posedge clk); while (tick !== 1'b1);
      end
   endtask

   task automatic edge_then_look();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; en = 1'b0; uvlo_ok = 1'b1; thermal_ok = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic full_power_up(input string req);
      @(negedge clk) en = 1'b1;
      @(posedge clk);
      wait_ticks(16); #1;
      check(req, 6'b111111, 1'b0);
      wait_ticks(1); #1;
      check(req, 6'b111111, 1'b1);
   endtask

   initial begin
      // R1: reset holds everything off even with enable high
      en = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 in reset", 6'b000000, 1'b0);
      en = 1'b0;
      rst_n = 1'b1;
      wait_ticks(3); #1;
      check("R1 after reset", 6'b000000, 1'b0);

      // R2/R3/R4: table walk through full power-up and power-down
      for (int s = 0; s < NSTEP; s++) begin
         @(negedge clk) en = STEPS[s][11];
         if (STEPS[s][10:7] == 4'd0) @(posedge clk);
         else wait_ticks(int'(STEPS[s][10:7]));
         #1;
         check(s < 14 ? "R2 power-up table" : "R4 power-down table",
               STEPS[s][6:1], STEPS[s][0]);
      end

      // R5: enable drops mid power-up, after VNEG
      do_reset();
      @(negedge clk) en = 1'b1;
      @(posedge clk);
      wait_ticks(9); #1;
      check("R5 partial up", 6'b000111, 1'b0);
      @(negedge clk) en = 1'b0;
      edge_then_look();
      check("R5 highest dropped first", 6'b000011, 1'b0);
      wait_ticks(1); #1;
      check("R5 gap hold", 6'b000011, 1'b0);
      wait_ticks(1); #1;
      check("R5 gate-low off", 6'b000001, 1'b0);
      // R9: enable returns high during power-down
      @(negedge clk) en = 1'b1;
      wait_ticks(5); #1;
      check("R9 down continues", 6'b000001, 1'b0);
      wait_ticks(1); #1;
      check("R9 down completes", 6'b000000, 1'b0);
      @(posedge clk);
      wait_ticks(1); #1;
      check("R9 restart not yet", 6'b000000, 1'b0);
      wait_ticks(1); #1;
      check("R9 restart first rail", 6'b000001, 1'b0);

      // R5: enable drops before any rail is on
      do_reset();
      @(negedge clk) en = 1'b1;
      @(posedge clk);
      wait_ticks(1);
      @(negedge clk) en = 1'b0;
      wait_ticks(5); #1;
      check("R5 nothing on", 6'b000000, 1'b0);

      // R6: undervoltage with enable high from idle
      do_reset();
      @(negedge clk) begin uvlo_ok = 1'b0; en = 1'b1; end
      wait_ticks(20); #1;
      check("R6 no start in undervoltage", 6'b000000, 1'b0);
      @(negedge clk) uvlo_ok = 1'b1;
      wait_ticks(20); #1;
      check("R8 needs enable toggle", 6'b000000, 1'b0);
      @(negedge clk) en = 1'b0;
      @(posedge clk);
      full_power_up("R8 restart after toggle");

      // R6: undervoltage at full power
      @(negedge clk) uvlo_ok = 1'b0;
      edge_then_look();
      check("R6 all off at once", 6'b000000, 1'b0);
      @(negedge clk) uvlo_ok = 1'b1;
      wait_ticks(20); #1;
      check("R8 stays off after clear", 6'b000000, 1'b0);

      // R7: over-temperature during power-up
      do_reset();
      @(negedge clk) en = 1'b1;
      @(posedge clk);
      wait_ticks(10); #1;
      check("R7 partial up", 6'b000111, 1'b0);
      @(negedge clk) thermal_ok = 1'b0;
      edge_then_look();
      check("R7 all off at once", 6'b000000, 1'b0);
      @(negedge clk) en = 1'b0;
      @(negedge clk) en = 1'b1;
      wait_ticks(20); #1;
      check("R8 toggle during fault ignored", 6'b000000, 1'b0);
      @(negedge clk) begin thermal_ok = 1'b1; en = 1'b0; end
      @(posedge clk);
      full_power_up("R8 restart after thermal");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule